// File: doc/BRIEF.md
# Qualified Performance Event Counter Bank

This block holds four wide event counters for a processor core. Each cycle the core presents a per-event occurrence count for every monitored event, the coherence state of the cache line involved in line-related events, and the current privilege level. Each counter picks one event through its control word and applies a chain of qualifiers to it: privilege filtering, cache-line-state masking, an optional per-cycle threshold test that can be inverted, and optional rising-edge-only counting. It then adds the result to its 48-bit count.

Software reaches the controls and the counts through a small address-decoded register port. Reads are combinational and writes take effect at the next clock edge. Each counter keeps a sticky overflow flag that is set when the count wraps. It drives its own interrupt line while the flag is set and its interrupt enable is on.

Inside every counter there are two small state machines. The edge tracker has states EDGE_LOW and EDGE_HIGH. It goes EDGE_LOW to EDGE_HIGH when the qualified condition is true in a cycle, and EDGE_HIGH to EDGE_LOW when it is false. The overflow tracker has states OVF_CLEAR and OVF_PENDING. It goes OVF_CLEAR to OVF_PENDING when an increment carries out of bit 47, and OVF_PENDING to OVF_CLEAR on a write to that counter's control word.

Top module: `pec_bank`

## Requirements
- R1: After reset all counts, control words and overflow flags read as zero and every interrupt line is low.
- R2: The port address is {kind, index}: kind 0 selects control word `index` and kind 1 selects count `index`. A write loads the value at the next edge and a read returns it at once. A count write wins over any increment in the same cycle. The control word layout is: select [7:0], state mask [12:8], threshold [15:13], invert 16, edge 17, level-0 enable 18, level-1..3 enable 19, interrupt enable 20, counter enable 21. A control read also shows the overflow flag in bit 22.
- R3: With threshold 0 and edge off, an enabled counter adds the selected event's lane value each cycle. A disabled counter holds its count.
- R4: With a nonzero threshold and invert clear, the counter adds one in each cycle where the lane value is at least the threshold, and nothing otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in each cycle where the lane value is below the threshold, zero included. Invert has no effect at threshold 0.
- R6: In edge mode the counter adds one only in a cycle where the qualified condition is true and was not true in the previous cycle. The condition at threshold 0 is a nonzero lane value. Cycles where the counter is disabled or filtered leave the history false, so a condition already true at enable time gives exactly one count.
- R7: Bit 18 allows counting at privilege level 0 and bit 19 allows counting at levels 1, 2 and 3. In a cycle whose level is not allowed, the count does not change.
- R8: For selects 0x42, 0x43 and 0x44 only, the lane value is treated as zero unless the mask bit for the line state is set. Line states are encoded 0 Modified, 1 Owner, 2 Exclusive, 3 Shared, 4 Invalid, and state k maps to control bit 8+k.
- R9: The recognized selects map to lanes of `ev_count` in ascending code order. 0x40..0x47 go to lanes 0..7, 0x80/0x81 to 8/9, 0x84/0x85 to 10/11, 0xC0..0xC7 to 12..19 and 0xCD..0xCF to 20..22. Lane k is `ev_count[3k+2:3k]`. Any other select leaves the count unchanged.
- R10: The count wraps from 2^48-1 to 0. A wrap caused by an increment sets the sticky overflow flag, and a control write clears it.
- R11: `irq[i]` is high exactly while counter i's overflow flag is set and its interrupt enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_count | input | 69 | Per-event occurrence counts, 23 lanes of 3 bits |
| line_state | input | 3 | Coherence state of the line for line events |
| priv | input | 2 | Current privilege level, 0 most privileged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | {kind, counter index} |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Register read data, combinational |
| irq | output | 4 | Per-counter overflow interrupt |

## Verification
A stuck edge tracker shows up as a missing or repeated count: on the first cycle after a condition turns true, the count is off by one and stays off. A wrong overflow state shows up on `irq` in the same cycle as the wrap, or fails to drop on the control write that should clear it. A fault in qualification shows up as a count that differs from the lane-by-lane expected sum at the next readback. Reads are combinational, so any such fault is visible one edge after the cycle that caused it.

// File: rtl/pec_pkg.sv
`timescale 1ns/1ps
package pec_pkg;

    localparam int EV_W   = 3;
    localparam int NUM_EV = 23;
    localparam int CTL_W  = 22;
    localparam int LANE_W = 5;

    typedef enum logic [2:0] {
        LS_MOD = 3'd0,
        LS_OWN = 3'd1,
        LS_EXC = 3'd2,
        LS_SHR = 3'd3,
        LS_INV = 3'd4
    } line_st_e;

    typedef struct packed {
        logic            en;
        logic            irq_en;
        logic            usr;
        logic            kern;
        logic            edge_m;
        logic            inv;
        logic [EV_W-1:0] thr;
        logic [4:0]      umask;
        logic [7:0]      sel;
    } ctl_t;

    typedef struct packed {
        logic              hit;
        logic [LANE_W-1:0] idx;
    } lane_t;

    typedef enum logic {EDGE_LOW, EDGE_HIGH} edge_st_e;
    typedef enum logic {OVF_CLEAR, OVF_PENDING} ovf_st_e;

    // Map an event select code onto its input lane.
    function automatic lane_t lane_of(input logic [7:0] code);
        lane_t r;
        r.hit = 1'b1;
        r.idx = '0;
        if (code[7:3] == 5'b01000)
            r.idx = {2'b00, code[2:0]};
        else if (code == 8'h80 || code == 8'h81)
            r.idx = 5'd8 + {4'b0000, code[0]};
        else if (code == 8'h84 || code == 8'h85)
            r.idx = 5'd10 + {4'b0000, code[0]};
        else if (code[7:3] == 5'b11000)
            r.idx = 5'd12 + {2'b00, code[2:0]};
        else if (code >= 8'hCD && code <= 8'hCF)
            r.idx = 5'd19 + {3'b000, code[1:0]};
        else
            r.hit = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pec_event_qual.sv
`timescale 1ns/1ps
module pec_event_qual
    import pec_pkg::*;
(
    input  logic [7:0]             sel,
    input  logic [4:0]             umask,
    input  logic [EV_W-1:0]        thr,
    input  logic                   inv,
    input  logic                   kern,
    input  logic                   usr,
    input  logic                   en,
    input  logic [NUM_EV*EV_W-1:0] ev_flat,
    input  logic [2:0]             line_state,
    input  logic [1:0]             priv,
    output logic                   gate,
    output logic                   cond,
    output logic [EV_W-1:0]        amount
);

    lane_t           lane;
    logic [EV_W-1:0] picked;
    logic [EV_W-1:0] raw;
    logic            is_line_ev;
    logic            state_ok;
    logic            priv_ok;

    always_comb begin
        lane   = lane_of(sel);
        picked = lane.hit ? ev_flat[lane.idx*EV_W +: EV_W] : '0;

        is_line_ev = (sel >= 8'h42) && (sel <= 8'h44);
        case (line_st_e'(line_state))
            LS_MOD:  state_ok = umask[0];
            LS_OWN:  state_ok = umask[1];
            LS_EXC:  state_ok = umask[2];
            LS_SHR:  state_ok = umask[3];
            LS_INV:  state_ok = umask[4];
            default: state_ok = 1'b0;
        endcase
        raw = (is_line_ev && !state_ok) ? '0 : picked;

        priv_ok = (priv == 2'd0) ? kern : usr;
        gate    = en && priv_ok && lane.hit;

        if (thr == '0) begin
            cond   = (raw != '0);
            amount = raw;
        end else begin
            cond   = inv ? (raw < thr) : (raw >= thr);
            amount = {{(EV_W-1){1'b0}}, cond};
        end
    end

endmodule

// File: rtl/pec_slot.sv
`timescale 1ns/1ps
module pec_slot
    import pec_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic                   cnt_we,
    input  logic [CNT_W-1:0]       wdata,
    input  logic [NUM_EV*EV_W-1:0] ev_flat,
    input  logic [2:0]             line_state,
    input  logic [1:0]             priv,
    output ctl_t                   ctl_q,
    output logic [CNT_W-1:0]       cnt_q,
    output logic                   ovf_q,
    output logic                   irq
);

    logic            gate;
    logic            cond;
    logic [EV_W-1:0] amount;

    pec_event_qual u_qual (
        .sel        (ctl_q.sel),
        .umask      (ctl_q.umask),
        .thr        (ctl_q.thr),
        .inv        (ctl_q.inv),
        .kern       (ctl_q.kern),
        .usr        (ctl_q.usr),
        .en         (ctl_q.en),
        .ev_flat    (ev_flat),
        .line_state (line_state),
        .priv       (priv),
        .gate       (gate),
        .cond       (cond),
        .amount     (amount)
    );

    edge_st_e        edge_st, edge_nx;
    ovf_st_e         ovf_st, ovf_nx;
    logic            hit_now;
    logic [EV_W-1:0] step;
    logic [CNT_W:0]  sum;
    logic            wrap;

    always_comb begin
        hit_now = gate && cond;

        unique case (edge_st)
            EDGE_LOW:  edge_nx = hit_now ? EDGE_HIGH : EDGE_LOW;
            EDGE_HIGH: edge_nx = hit_now ? EDGE_HIGH : EDGE_LOW;
            default:   edge_nx = EDGE_LOW;
        endcase

        if (!gate)
            step = '0;
        else if (ctl_q.edge_m)
            step = (hit_now && edge_st == EDGE_LOW) ? {{(EV_W-1){1'b0}}, 1'b1} : '0;
        else
            step = amount;

        sum  = {1'b0, cnt_q} + {{(CNT_W+1-EV_W){1'b0}}, step};
        wrap = sum[CNT_W] && !cnt_we;

        unique case (ovf_st)
            OVF_CLEAR:   ovf_nx = (wrap && !ctl_we) ? OVF_PENDING : OVF_CLEAR;
            OVF_PENDING: ovf_nx = ctl_we ? OVF_CLEAR : OVF_PENDING;
            default:     ovf_nx = OVF_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_st <= EDGE_LOW;
            ovf_st  <= OVF_CLEAR;
            ctl_q   <= '0;
            cnt_q   <= '0;
        end else begin
            edge_st <= edge_nx;
            ovf_st  <= ovf_nx;
            if (ctl_we)
                ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
            if (cnt_we)
                cnt_q <= wdata;
            else
                cnt_q <= sum[CNT_W-1:0];
        end
    end

    always_comb begin
        ovf_q = (ovf_st == OVF_PENDING);
        irq   = ovf_q && ctl_q.irq_en;
    end

    assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(wdata));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.en && !cnt_we) |=> cnt_q == $past(cnt_q));

    assert_thr_unit_step_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.thr != '0 && !cnt_we) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.edge_m && !cnt_we) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    assert_priv_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.kern && priv == 2'd0 && !cnt_we) |=> cnt_q == $past(cnt_q));

    assert_unknown_code_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_of(ctl_q.sel).hit && !cnt_we) |=> cnt_q == $past(cnt_q));

    assert_flag_on_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(cnt_q) > cnt_q);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ctl_we) |=> ovf_q);

endmodule

// File: rtl/pec_bank.sv
`timescale 1ns/1ps
module pec_bank
    import pec_pkg::*;
#(
    parameter  int CNT_W   = 48,
    parameter  int NUM_CNT = 4,
    localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EV*EV_W-1:0] ev_count,
    input  logic [2:0]             line_state,
    input  logic [1:0]             priv,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [CNT_W-1:0]       reg_wdata,
    output logic [CNT_W-1:0]       reg_rdata,
    output logic [NUM_CNT-1:0]     irq
);

    ctl_t             ctl_v [NUM_CNT];
    logic [CNT_W-1:0] cnt_v [NUM_CNT];
    logic             ovf_v [NUM_CNT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        logic hit_me;
        assign hit_me = reg_wr && (reg_addr[IDX_W-1:0] == IDX_W'(g));

        pec_slot #(.CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we     (hit_me && !reg_addr[IDX_W]),
            .cnt_we     (hit_me && reg_addr[IDX_W]),
            .wdata      (reg_wdata),
            .ev_flat    (ev_count),
            .line_state (line_state),
            .priv       (priv),
            .ctl_q      (ctl_v[g]),
            .cnt_q      (cnt_v[g]),
            .ovf_q      (ovf_v[g]),
            .irq        (irq[g])
        );
    end

    logic [IDX_W-1:0] rd_idx;

    always_comb begin
        rd_idx    = reg_addr[IDX_W-1:0];
        reg_rdata = '0;
        if (int'(rd_idx) < NUM_CNT) begin
            if (reg_addr[IDX_W])
                reg_rdata = cnt_v[rd_idx];
            else
                reg_rdata = CNT_W'({ovf_v[rd_idx], ctl_v[rd_idx]});
        end
    end

endmodule

// File: tb/pec_bank_tb.sv
`timescale 1ns/1ps
module pec_bank_tb;
    import pec_pkg::*;

    localparam int CNT_W   = 48;
    localparam int NUM_CNT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NUM_EV*EV_W-1:0] ev_count = '0;
    logic [2:0]             line_state = '0;
    logic [1:0]             priv = '0;
    logic                   reg_wr = 1'b0;
    logic [2:0]             reg_addr = '0;
    logic [CNT_W-1:0]       reg_wdata = '0;
    logic [CNT_W-1:0]       reg_rdata;
    logic [NUM_CNT-1:0]     irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    pec_bank #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_count(ev_count), .line_state(line_state),
        .priv(priv), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model built from the requirements.
    logic [47:0] m_cnt [4];
    logic [21:0] m_ctl [4];
    bit          m_prev [4];
    bit          m_ovf [4];

    function automatic int m_lane(input logic [7:0] c);
        if (c >= 8'h40 && c <= 8'h47) return int'(c) - 'h40;
        if (c == 8'h80 || c == 8'h81) return int'(c) - 'h80 + 8;
        if (c == 8'h84 || c == 8'h85) return int'(c) - 'h84 + 10;
        if (c >= 8'hC0 && c <= 8'hC7) return int'(c) - 'hC0 + 12;
        if (c >= 8'hCD && c <= 8'hCF) return int'(c) - 'hCD + 20;
        return -1;
    endfunction

    function automatic int m_step(input logic [21:0] c, input bit prev, output bit hit);
        int ln, raw, th;
        bit pok, cnd;
        ln  = m_lane(c[7:0]);
        raw = (ln >= 0) ? int'(ev_count[ln*3 +: 3]) : 0;
        if (c[7:0] >= 8'h42 && c[7:0] <= 8'h44)
            if (!(line_state < 3'd5 && c[8 + int'(line_state)])) raw = 0;
        pok = (priv == 2'd0) ? c[18] : c[19];
        th  = int'(c[15:13]);
        if (th == 0) cnd = (raw != 0);
        else         cnd = c[16] ? (raw < th) : (raw >= th);
        hit = c[21] && pok && (ln >= 0) && cnd;
        if (!hit) return 0;
        if (c[17]) return prev ? 0 : 1;
        return (th == 0) ? raw : 1;
    endfunction

    function automatic logic [3:0] m_irq();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_ovf[i] && m_ctl[i][20];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] <= '0; m_ctl[i] <= '0; m_prev[i] <= 1'b0; m_ovf[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit h;
                int a;
                logic [48:0] s;
                bit cw, kw;
                a  = m_step(m_ctl[i], m_prev[i], h);
                s  = {1'b0, m_cnt[i]} + 49'(a);
                cw = reg_wr && reg_addr == {1'b1, 2'(i)};
                kw = reg_wr && reg_addr == {1'b0, 2'(i)};
                m_prev[i] <= h;
                m_cnt[i]  <= cw ? reg_wdata : s[47:0];
                if (kw) begin
                    m_ctl[i] <= reg_wdata[21:0];
                    m_ovf[i] <= 1'b0;
                end else if (s[48] && !cw) begin
                    m_ovf[i] <= 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 4; i++) begin
            reg_addr = {1'b1, 2'(i)}; #0.2;
            check(reg_rdata === m_cnt[i], req, 64'(reg_rdata), 64'(m_cnt[i]));
            reg_addr = {1'b0, 2'(i)}; #0.2;
            check(reg_rdata === {25'b0, m_ovf[i], m_ctl[i]}, req, 64'(reg_rdata),
                  64'({25'b0, m_ovf[i], m_ctl[i]}));
        end
        check(irq === m_irq(), req, 64'(irq), 64'(m_irq()));
    endtask

    task automatic cnt_is(input int i, input logic [47:0] exp, input string req);
        reg_addr = {1'b1, 2'(i)}; #0.2;
        check(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic ovf_is(input int i, input bit exp, input string req);
        reg_addr = {1'b0, 2'(i)}; #0.2;
        check(reg_rdata[22] === exp, req, 64'(reg_rdata[22]), 64'(exp));
    endtask

    task automatic irq_is(input logic [3:0] exp, input string req);
        check(irq === exp, req, 64'(irq), 64'(exp));
    endtask

    task automatic wr(input logic [2:0] a, input logic [47:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lane(input int l, input int v);
        ev_count[l*3 +: 3] = 3'(v);
    endtask

    function automatic logic [47:0] mk(input logic [7:0] sel, input logic [4:0] um,
                                       input logic [2:0] thr, input bit inv, input bit edg,
                                       input bit kern, input bit usr, input bit ie, input bit en);
        return {26'b0, en, ie, usr, kern, edg, inv, thr, um, sel};
    endfunction

    function automatic logic [7:0] code_for(input int j);
        if (j < 8)  return 8'(8'h40 + j);
        if (j < 10) return 8'(8'h80 + j - 8);
        if (j < 12) return 8'(8'h84 + j - 10);
        if (j < 20) return 8'(8'hC0 + j - 12);
        return 8'(8'hCD + j - 20);
    endfunction

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        run(3);
        rst_n = 1'b1;
        run(1);
        sweep("R1");
        irq_is(4'b0000, "R1");

        // R3 plain counting and hold when disabled
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 1, 0, 1));
        wr(3'b100, 48'd0);
        lane(0, 5); run(3); ev_count = '0;
        cnt_is(0, 48'd15, "R3");
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 1, 0, 0));
        lane(0, 5); run(3); ev_count = '0;
        cnt_is(0, 48'd15, "R3");

        // R2 count write wins over increment
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 1, 0, 1));
        lane(0, 7); run(2);
        wr(3'b100, 48'h123);
        cnt_is(0, 48'h123, "R2");
        run(1);
        cnt_is(0, 48'h12A, "R2");
        ev_count = '0;
        sweep("R2");

        // R4 threshold
        wr(3'b000, mk(8'h40, 0, 3, 0, 0, 1, 1, 0, 1));
        wr(3'b100, 48'd0);
        lane(0, 2); run(1); lane(0, 3); run(1); lane(0, 7); run(1); ev_count = '0;
        cnt_is(0, 48'd2, "R4");

        // R5 inverted threshold
        wr(3'b000, mk(8'h40, 0, 3, 1, 0, 1, 1, 0, 0));
        wr(3'b100, 48'd0);
        lane(0, 2);
        wr(3'b000, mk(8'h40, 0, 3, 1, 0, 1, 1, 0, 1));
        run(1); lane(0, 3); run(1); lane(0, 0); run(1); lane(0, 6);
        cnt_is(0, 48'd2, "R5");
        wr(3'b000, mk(8'h40, 0, 3, 1, 0, 1, 1, 0, 0));
        ev_count = '0;

        // R6 edge mode
        wr(3'b000, mk(8'h40, 0, 0, 0, 1, 1, 1, 0, 1));
        wr(3'b100, 48'd0);
        lane(0, 1); run(3); lane(0, 0); run(1); lane(0, 2); run(1);
        cnt_is(0, 48'd2, "R6");
        ev_count = '0;
        wr(3'b000, mk(8'h40, 0, 0, 0, 1, 1, 1, 0, 0));
        wr(3'b100, 48'd0);
        lane(0, 1); run(2);
        wr(3'b000, mk(8'h40, 0, 0, 0, 1, 1, 1, 0, 1));
        run(3);
        cnt_is(0, 48'd1, "R6");
        ev_count = '0;

        // R7 privilege filter
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 0, 0, 1));
        wr(3'b100, 48'd0);
        lane(0, 1); priv = 2'd2; run(3);
        cnt_is(0, 48'd0, "R7");
        priv = 2'd0; run(2);
        cnt_is(0, 48'd2, "R7");
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 0, 1, 0, 1));
        run(2);
        cnt_is(0, 48'd3, "R7");
        priv = 2'd3; run(2);
        cnt_is(0, 48'd5, "R7");
        ev_count = '0; priv = 2'd0;

        // R8 line-state mask
        wr(3'b000, mk(8'h42, 5'b01000, 0, 0, 0, 1, 1, 0, 1));
        wr(3'b100, 48'd0);
        lane(2, 4); line_state = 3'd3; run(2);
        cnt_is(0, 48'd8, "R8");
        line_state = 3'd0; run(2); line_state = 3'd4; run(1);
        cnt_is(0, 48'd8, "R8");
        wr(3'b000, mk(8'h42, 5'b11111, 0, 0, 0, 1, 1, 0, 1));
        run(1);
        cnt_is(0, 48'd12, "R8");
        ev_count = '0; line_state = 3'd0;

        // R9 unrecognized and recognized selects
        wr(3'b000, mk(8'h50, 0, 0, 0, 0, 1, 1, 0, 1));
        wr(3'b100, 48'd0);
        ev_count = '1; run(3);
        cnt_is(0, 48'd0, "R9");
        wr(3'b000, mk(8'hCB, 0, 0, 0, 0, 1, 1, 0, 1));
        run(2);
        cnt_is(0, 48'd0, "R9");
        wr(3'b000, mk(8'hCF, 0, 0, 0, 0, 1, 1, 0, 1));
        run(1);
        cnt_is(0, 48'd7, "R9");
        ev_count = '0;

        // R10 / R11 wrap, sticky flag and interrupt
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 1, 1, 1));
        wr(3'b100, 48'hFFFF_FFFF_FFFE);
        lane(0, 1); run(1);
        cnt_is(0, 48'hFFFF_FFFF_FFFF, "R10");
        irq_is(4'b0000, "R11");
        run(1);
        cnt_is(0, 48'd0, "R10");
        ovf_is(0, 1'b1, "R10");
        irq_is(4'b0001, "R11");
        ev_count = '0; run(2);
        irq_is(4'b0001, "R11");
        wr(3'b000, mk(8'h40, 0, 0, 0, 0, 1, 1, 1, 0));
        ovf_is(0, 1'b0, "R10");
        irq_is(4'b0000, "R11");
        wr(3'b001, mk(8'h40, 0, 0, 0, 0, 1, 1, 0, 1));
        wr(3'b101, 48'hFFFF_FFFF_FFFF);
        lane(0, 3); run(1); ev_count = '0;
        cnt_is(1, 48'd2, "R10");
        ovf_is(1, 1'b1, "R10");
        irq_is(4'b0000, "R11");
        wr(3'b001, 48'd0);
        sweep("R10");

        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            int r;
            for (int l = 0; l < NUM_EV; l++) lane(l, ($urandom % 3 == 0) ? int'($urandom % 8) : 0);
            priv       = 2'($urandom % 4);
            line_state = 3'($urandom % 5);
            r = int'($urandom % 32);
            if (r == 0) begin
                logic [7:0] sel;
                sel = ($urandom % 5 == 0) ? 8'($urandom) : code_for(int'($urandom % NUM_EV));
                wr({1'b0, 2'($urandom)}, {26'b0, ($urandom % 4 != 0), 13'($urandom), sel});
            end else if (r == 1) begin
                wr({1'b1, 2'($urandom)}, ($urandom % 2 == 0) ? {40'hFF_FFFF_FFFF, 8'($urandom)}
                                                             : {16'($urandom), 32'($urandom)});
            end else begin
                run(1);
            end
            irq_is(m_irq(), "R11");
            if (c % 50 == 0) sweep("R3");
        end
        sweep("R3");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule